// File: doc/BRIEF.md
# Masked Memory Checksum Accumulator

This block forms a 16-bit verification sum over a device image as it streams past. A separate read sequencer (not part of this block) presents 24-bit code words with their addresses and 16-bit configuration register values with a register index, each on its own valid strobe. The block adds every byte of the accepted data into a running sum. Configuration values are first ANDed with a fixed per-register mask. A code-protection setting selects between two result forms. In the first, the sum covers the masked configuration block plus the code words that fall inside an inclusive address window. In the second, only the configuration block counts, and one register is assumed to hold a fixed value instead of what was read.

The window bounds and the protection flag are captured on a start pulse. The start pulse also clears the sum. An end-of-stream strobe closes the run. A one-cycle done pulse follows, and the sum stays on its output until the next start.

The controller is a three-state machine:
- **IDLE**: waits, and ignores data.
- **RUN**: accumulates.
- **DONE**: raises done for one cycle.

Its transitions are:
- *arm*: IDLE→RUN on start.
- *restart*: RUN→RUN on start.
- *close*: RUN→DONE on the end strobe.
- *retire*: DONE→IDLE when there is no start.
- *rearm*: DONE→RUN on start.

Top module: `csum_engine`

## Requirements
- R1: After reset the sum is 0 and the block is idle (busy and done low). A start pulse clears the sum to 0, captures the window bounds and the protection flag, and enters RUN. Start takes priority over any data presented in the same cycle, and that data is not added.
- R2: In RUN with protection off, a code word whose address satisfies low ≤ address ≤ high adds its three bytes (bits 7:0, 15:8, 23:16) to the sum. Both bounds are included.
- R3: In RUN, a code word whose address is below the low bound or above the high bound leaves the sum unchanged.
- R4: In RUN, a configuration value with index 0..6 is ANDed with that index's mask before its two bytes are added. The masks are 0: 0xC10F, 1: 0x803F, 2: 0x87B3, 3: 0x310F, 4: 0x330F, 5: 0x0007 and 6: 0xC003. Index 7 adds nothing.
- R5: With protection on, code words add nothing, whatever their address.
- R6: With protection on, a value with index 5 is replaced by 0x0005 before masking.
- R7: A code word and a configuration value accepted in the same cycle are both added.
- R8: The sum is kept modulo 2^16 and wraps without saturating.
- R9: When the end strobe is seen in RUN, done is high for exactly the next cycle, and the block then returns to idle. Data presented together with the end strobe is still added.
- R10: Outside RUN, code words, configuration values and end strobes have no effect. The sum holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse: clears the sum, captures the settings |
| win_lo_i | input | 24 | Low bound of the code address window (inclusive) |
| win_hi_i | input | 24 | High bound of the code address window (inclusive) |
| protect_i | input | 1 | Code-protection setting, captured on start |
| code_vld_i | input | 1 | Code word valid |
| code_addr_i | input | 24 | Code word address |
| code_data_i | input | 24 | Code word data |
| cfg_vld_i | input | 1 | Configuration value valid |
| cfg_idx_i | input | 3 | Configuration register index |
| cfg_data_i | input | 16 | Configuration register value |
| last_i | input | 1 | End-of-stream strobe |
| busy_o | output | 1 | High while in RUN |
| done_o | output | 1 | One-cycle pulse after the run closes |
| sum_o | output | 16 | Running or final checksum |

## Verification
The bench builds the block with its default parameters:
- a 24-bit address,
- three bytes per code word,
- a 16-bit sum.

With these values, about 86 words of all-ones data are enough to wrap the sum. The 24-bit window compare can also be probed one address inside and one outside each bound. Directed runs exercise each mask, the substituted protected register and start-over-data priority. Seeded random runs mix in-window words, out-of-window words and simultaneous beats under both protection settings.

// File: rtl/csum_pkg.sv
package csum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } csum_state_e;

    localparam int CFG_REGS  = 7;
    localparam int CFG_W     = 16;
    localparam int CFG_IDX_W = $clog2(CFG_REGS + 1);

    // Per-register keep mask; indices beyond the block contribute nothing.
    function automatic logic [CFG_W-1:0] cfg_mask(input logic [CFG_IDX_W-1:0] idx);
        logic [CFG_W-1:0] m;
        case (idx)
            3'd0:    m = 16'hC10F;
            3'd1:    m = 16'h803F;
            3'd2:    m = 16'h87B3;
            3'd3:    m = 16'h310F;
            3'd4:    m = 16'h330F;
            3'd5:    m = 16'h0007;
            3'd6:    m = 16'hC003;
            default: m = 16'h0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/csum_ctrl.sv
module csum_ctrl
    import csum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    output logic run_o,
    output logic done_o
);

    csum_state_e state_q;
    csum_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, restart, close, retire, rearm
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  state_d = last_i ? ST_DONE : ST_RUN;
                ST_DONE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        run_o  = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  run_o  = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/csum_code_path.sv
module csum_code_path #(
    parameter int ADDR_W     = 24,
    parameter int CODE_BYTES = 3,
    parameter int SUM_W      = 16
) (
    input  logic                  run_i,
    input  logic                  prot_i,
    input  logic                  vld_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [8*CODE_BYTES-1:0] data_i,
    input  logic [ADDR_W-1:0]     lo_i,
    input  logic [ADDR_W-1:0]     hi_i,
    output logic [SUM_W-1:0]      add_o
);

    logic [SUM_W-1:0] part [CODE_BYTES+1];
    logic             in_win;
    logic             take;

    assign part[0] = '0;

    generate
        for (genvar b = 0; b < CODE_BYTES; b++) begin : g_byte
            assign part[b+1] = part[b] + SUM_W'(data_i[8*b +: 8]);
        end
    endgenerate

    assign in_win = (addr_i >= lo_i) && (addr_i <= hi_i);
    assign take   = run_i && !prot_i && vld_i && in_win;
    assign add_o  = take ? part[CODE_BYTES] : '0;

endmodule

// File: rtl/csum_cfg_path.sv
module csum_cfg_path
    import csum_pkg::*;
#(
    parameter int               SUM_W    = 16,
    parameter int               PROT_IDX = 5,
    parameter logic [CFG_W-1:0] PROT_VAL = 16'h0005
) (
    input  logic                 run_i,
    input  logic                 prot_i,
    input  logic                 vld_i,
    input  logic [CFG_IDX_W-1:0] idx_i,
    input  logic [CFG_W-1:0]     data_i,
    output logic [SUM_W-1:0]     add_o
);

    logic [CFG_W-1:0] raw;
    logic [CFG_W-1:0] kept;

    assign raw   = (prot_i && (idx_i == CFG_IDX_W'(PROT_IDX))) ? PROT_VAL : data_i;
    assign kept  = raw & cfg_mask(idx_i);
    assign add_o = (run_i && vld_i) ? (SUM_W'(kept[7:0]) + SUM_W'(kept[15:8])) : '0;

endmodule

// File: rtl/csum_engine.sv
module csum_engine
    import csum_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int CODE_BYTES = 3,
    parameter int SUM_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       win_lo_i,
    input  logic [ADDR_W-1:0]       win_hi_i,
    input  logic                    protect_i,
    input  logic                    code_vld_i,
    input  logic [ADDR_W-1:0]       code_addr_i,
    input  logic [8*CODE_BYTES-1:0] code_data_i,
    input  logic                    cfg_vld_i,
    input  logic [CFG_IDX_W-1:0]    cfg_idx_i,
    input  logic [CFG_W-1:0]        cfg_data_i,
    input  logic                    last_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [SUM_W-1:0]        sum_o
);

    logic              run;
    logic [ADDR_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_q;
    logic              prot_q;
    logic [SUM_W-1:0]  acc_q;
    logic [SUM_W-1:0]  code_add;
    logic [SUM_W-1:0]  cfg_add;

    csum_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .last_i  (last_i),
        .run_o   (run),
        .done_o  (done_o)
    );

    // Run settings, captured on start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            prot_q <= 1'b0;
        end else if (start_i) begin
            lo_q   <= win_lo_i;
            hi_q   <= win_hi_i;
            prot_q <= protect_i;
        end
    end

    csum_code_path #(
        .ADDR_W     (ADDR_W),
        .CODE_BYTES (CODE_BYTES),
        .SUM_W      (SUM_W)
    ) u_code (
        .run_i  (run),
        .prot_i (prot_q),
        .vld_i  (code_vld_i),
        .addr_i (code_addr_i),
        .data_i (code_data_i),
        .lo_i   (lo_q),
        .hi_i   (hi_q),
        .add_o  (code_add)
    );

    csum_cfg_path #(
        .SUM_W (SUM_W)
    ) u_cfg (
        .run_i  (run),
        .prot_i (prot_q),
        .vld_i  (cfg_vld_i),
        .idx_i  (cfg_idx_i),
        .data_i (cfg_data_i),
        .add_o  (cfg_add)
    );

    // Accumulator: start clears with priority, otherwise add gated terms
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (start_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + code_add + cfg_add;
        end
    end

    assign busy_o = run;
    assign sum_o  = acc_q;

endmodule

// File: rtl/csum_chk.sv
module csum_chk #(
    parameter int SUM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             last_i,
    input logic             code_vld_i,
    input logic             cfg_vld_i,
    input logic [2:0]       cfg_idx_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [SUM_W-1:0] sum_o
);

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sum_o == '0) && busy_o);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R9
    done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && last_i && !start_i) |=> done_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(sum_o) && !busy_o);

    // R4
    spare_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i && !code_vld_i && cfg_vld_i && cfg_idx_i == 3'd7) |=> $stable(sum_o));

endmodule

bind csum_engine csum_chk #(.SUM_W(SUM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .last_i     (last_i),
    .code_vld_i (code_vld_i),
    .cfg_vld_i  (cfg_vld_i),
    .cfg_idx_i  (cfg_idx_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sum_o      (sum_o)
);

// File: tb/sim_csum_engine.sv
`timescale 1ns/1ps
module sim_csum_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] win_lo_i = '0;
    logic [23:0] win_hi_i = '0;
    logic        protect_i = 1'b0;
    logic        code_vld_i = 1'b0;
    logic [23:0] code_addr_i = '0;
    logic [23:0] code_data_i = '0;
    logic        cfg_vld_i = 1'b0;
    logic [2:0]  cfg_idx_i = '0;
    logic [15:0] cfg_data_i = '0;
    logic        last_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] sum_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_sum;
    logic [23:0] m_lo, m_hi;
    logic        m_prot;
    logic        m_run;

    always #10 clk = ~clk;

    csum_engine u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] code_sum(input logic [23:0] d);
        return 16'(d[7:0]) + 16'(d[15:8]) + 16'(d[23:16]);
    endfunction

    function automatic logic [15:0] cfg_sum(input logic [2:0] i, input logic [15:0] d, input logic p);
        logic [15:0] m, v;
        case (i)
            3'd0: m = 16'hC10F;
            3'd1: m = 16'h803F;
            3'd2: m = 16'h87B3;
            3'd3: m = 16'h310F;
            3'd4: m = 16'h330F;
            3'd5: m = 16'h0007;
            3'd6: m = 16'hC003;
            default: m = 16'h0000;
        endcase
        v = (p && i == 3'd5) ? 16'h0005 : d;
        v = v & m;
        return 16'(v[7:0]) + 16'(v[15:8]);
    endfunction

    task automatic clear_ins();
        start_i = 0; code_vld_i = 0; cfg_vld_i = 0; last_i = 0;
    endtask

    // Start a run; optionally present a code word in the same cycle (must be dropped)
    task automatic start_run(input logic [23:0] lo, input logic [23:0] hi, input logic p, input logic with_data);
        start_i = 1; win_lo_i = lo; win_hi_i = hi; protect_i = p;
        code_vld_i = with_data; code_addr_i = lo; code_data_i = 24'hFFFFFF;
        cfg_vld_i = with_data; cfg_idx_i = 3'd0; cfg_data_i = 16'hFFFF;
        m_sum = '0; m_lo = lo; m_hi = hi; m_prot = p; m_run = 1;
        @(negedge clk);
        clear_ins();
        check("R1 start clears", {16'h0, sum_o}, 32'h0);
        check("R1 busy after start", {31'h0, busy_o}, 32'h1);
    endtask

    task automatic beat(input logic cv, input logic [23:0] ca, input logic [23:0] cd,
                        input logic fv, input logic [2:0] fi, input logic [15:0] fd,
                        input logic lst, input string req);
        code_vld_i = cv; code_addr_i = ca; code_data_i = cd;
        cfg_vld_i = fv; cfg_idx_i = fi; cfg_data_i = fd; last_i = lst;
        if (m_run) begin
            if (cv && !m_prot && ca >= m_lo && ca <= m_hi) m_sum = m_sum + code_sum(cd);
            if (fv) m_sum = m_sum + cfg_sum(fi, fd, m_prot);
        end
        @(negedge clk);
        clear_ins();
        if (lst && m_run) begin
            m_run = 0;
            check({req, " R9 done pulse"}, {31'h0, done_o}, 32'h1);
            check({req, " final sum"}, {16'h0, sum_o}, {16'h0, m_sum});
            @(negedge clk);
            check("R9 done drops", {31'h0, done_o}, 32'h0);
            check("R10 sum holds", {16'h0, sum_o}, {16'h0, m_sum});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        m_run = 0; m_sum = 0; m_prot = 0; m_lo = 0; m_hi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset sum", {16'h0, sum_o}, 32'h0);
        check("R1 reset busy", {31'h0, busy_o}, 32'h0);
        check("R1 reset done", {31'h0, done_o}, 32'h0);

        // R2 R3: window edges
        start_run(24'h100, 24'h1FE, 0, 0);
        beat(1, 24'h0FF, 24'h123456, 0, 0, 0, 0, "R3");
        check("R3 below low ignored", {16'h0, sum_o}, 32'h0);
        beat(1, 24'h100, 24'h123456, 0, 0, 0, 0, "R2");
        check("R2 low bound counted", {16'h0, sum_o}, 32'h9C);
        beat(1, 24'h1FF, 24'h123456, 0, 0, 0, 0, "R3");
        check("R3 above high ignored", {16'h0, sum_o}, 32'h9C);
        beat(1, 24'h1FE, 24'h123456, 0, 0, 0, 1, "R2");
        check("R2 two edge words", {16'h0, sum_o}, 32'h138);

        // R4: all masks, spare index
        start_run(24'h0, 24'hFFFFFF, 0, 0);
        for (int i = 0; i < 8; i++) beat(0, 0, 0, 1, 3'(i), 16'hFFFF, 0, "R4");
        check("R4 masked block", {16'h0, sum_o}, 32'h415);
        beat(0, 0, 0, 0, 0, 0, 1, "R4");

        // R5 R6: protection
        start_run(24'h0, 24'hFFFFFF, 1, 0);
        beat(1, 24'h10, 24'hFFFFFF, 0, 0, 0, 0, "R5");
        check("R5 code ignored when protected", {16'h0, sum_o}, 32'h0);
        for (int i = 0; i < 7; i++) beat(0, 0, 0, 1, 3'(i), 16'hFFFF, 0, "R6");
        check("R6 substituted register", {16'h0, sum_o}, 32'h413);
        beat(0, 0, 0, 0, 0, 0, 1, "R6");

        // R7 + R9: simultaneous beats together with the end strobe
        start_run(24'h0, 24'h20, 0, 0);
        beat(1, 24'h5, 24'h010203, 1, 3'd6, 16'hFFFF, 1, "R7");
        check("R7 both terms", {16'h0, sum_o}, 32'hC9);

        // R8: wrap
        start_run(24'h0, 24'hFFFFFF, 0, 0);
        for (int i = 0; i < 100; i++) beat(1, 24'(i), 24'hFFFFFF, 0, 0, 0, i == 99, "R8");
        check("R8 wrap value", {16'h0, sum_o}, 32'd10964);

        // R10: beats and end strobe while idle
        beat(1, 24'h5, 24'hFFFFFF, 1, 3'd0, 16'hFFFF, 1, "R10");
        check("R10 idle beat ignored", {16'h0, sum_o}, 32'd10964);
        check("R10 idle end strobe", {31'h0, done_o}, 32'h0);

        // R1: start with same-cycle data, also a restart mid-run
        start_run(24'h0, 24'hFFFFFF, 0, 0);
        beat(1, 24'h1, 24'h111111, 0, 0, 0, 0, "R1");
        start_run(24'h0, 24'hFFFFFF, 0, 1);
        beat(0, 0, 0, 0, 0, 0, 1, "R1 restart");

        // Random runs
        for (int r = 0; r < 24; r++) begin
            logic [23:0] lo;
            lo = 24'($urandom_range(0, 255));
            start_run(lo, lo + 24'($urandom_range(0, 255)), $urandom_range(0, 3) == 0, 0);
            for (int b = 0; b < 40; b++)
                beat($urandom_range(0, 1) == 1, 24'($urandom_range(0, 600)), 24'($urandom),
                     $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)), 16'($urandom),
                     b == 39, "R2 R4 R5 R7 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule